// File: doc/BRIEF.md
# Atomic Compare-and-Swap Memory Unit

This unit carries out one indivisible compare-and-swap on a single 64-bit memory word. The caller supplies four operands and pulses `start_i`: an expected value, a replacement value, a base address and an offset. The unit latches all four operands. It reads the word at base plus offset and checks it against the expected value. The replacement value is written back only if the two are equal.

The unit reports the outcome on `ovf_o`. A value of 1 means the swap took place and 0 means the word did not match. `done_o` marks the end of each operation. Memory is reached through one request/acknowledge port that carries both reads and writes. While the read-compare-write sequence is in flight, `lock_o` is high so that an external arbiter keeps other requesters off the memory between the read and the write.

Top module: `cas_unit`

## Requirements
- R1: After reset, and while `rst_ni` is low, `mem_req_o`, `lock_o`, `done_o` and `ovf_o` are all 0.
- R2: Every memory request carries the address `base_i + offset_i` as captured at start, taken modulo 2^AW, so a sum that overflows wraps around.
- R3: The first request of an operation is a read, with `mem_we_o` = 0.
- R4: If the read data equals the expected value, exactly one write follows to the same address with the replacement value on `mem_wdata_o`, and `ovf_o` becomes 1.
- R5: If the read data differs from the expected value in any bit, no write is issued and `ovf_o` becomes 0.
- R6: `lock_o` is high on every cycle in which `mem_req_o` is high. It falls only on the cycle after an acknowledge, and it is low when `done_o` is high.
- R7: `done_o` is high for exactly one cycle per operation, on the cycle after the acknowledge that finishes the operation.
- R8: While an operation is in progress, `start_i` and any change on the operand inputs have no effect. The operation completes with the operands captured at start, and no second operation follows.
- R9: `ovf_o` changes only on a cycle where `done_o` is high, and between operations it holds the last result.
- R10: While a request waits for `mem_ack_i`, `mem_req_o`, `mem_addr_o`, `mem_we_o` and `mem_wdata_o` stay stable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin an operation; sampled only when idle |
| old_val_i | input | DW | Expected current value of the word |
| new_val_i | input | DW | Replacement value |
| base_i | input | AW | Base address |
| offset_i | input | AW | Address offset added to the base |
| mem_req_o | output | 1 | Memory request, held until acknowledged |
| mem_we_o | output | 1 | 1 = write, 0 = read |
| mem_addr_o | output | AW | Word address |
| mem_wdata_o | output | DW | Write data |
| mem_ack_i | input | 1 | One-cycle acknowledge; read data valid in the same cycle |
| mem_rdata_i | input | DW | Read data |
| lock_o | output | 1 | Exclusive-access hold for the memory arbiter |
| ovf_o | output | 1 | Swap success flag from the last operation |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
A controller stuck in or skipping a state shows at the ports within one acknowledge. Skipping shows as a write after a mismatch, or as a missing write after a match, both visible as the final memory contents and the write count. Being stuck shows as `done_o` never arriving or arriving twice. A comparator that ignores part of the word shows only for words that differ in that part, so the stimulus includes mismatches confined to the top bit and to the bottom bit. A bad address register shows on the first request as a wrong `mem_addr_o`, and a wrapping base-plus-offset sum exposes a truncated adder.

// File: rtl/cas_pkg.sv
package cas_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RD   = 2'd1,
    ST_WR   = 2'd2,
    ST_FIN  = 2'd3
  } cas_state_e;
endpackage

// File: rtl/cas_opnd_reg.sv
module cas_opnd_reg #(
  parameter int AW = 32,
  parameter int DW = 64
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [DW-1:0] old_val_i,
  input  logic [DW-1:0] new_val_i,
  input  logic [AW-1:0] base_i,
  input  logic [AW-1:0] offset_i,
  output logic [DW-1:0] old_q_o,
  output logic [DW-1:0] new_q_o,
  output logic [AW-1:0] addr_q_o
);
  // sum wraps at 2^AW
  logic [AW-1:0] addr_sum;
  assign addr_sum = base_i + offset_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      old_q_o  <= '0;
      new_q_o  <= '0;
      addr_q_o <= '0;
    end else if (load_i) begin
      old_q_o  <= old_val_i;
      new_q_o  <= new_val_i;
      addr_q_o <= addr_sum;
    end
  end
endmodule

// File: rtl/cas_cmp.sv
module cas_cmp #(
  parameter int DW     = 64,
  parameter int LANE_W = 16
) (
  input  logic [DW-1:0] a_i,
  input  logic [DW-1:0] b_i,
  output logic          eq_o
);
  localparam int LANES = (DW + LANE_W - 1) / LANE_W;
  localparam int PADW  = LANES * LANE_W;

  logic [PADW-1:0]  a_pad, b_pad;
  logic [LANES-1:0] lane_eq;

  assign a_pad = PADW'(a_i);
  assign b_pad = PADW'(b_i);

  // per-lane equality, then one AND tree
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign lane_eq[g] = (a_pad[g*LANE_W +: LANE_W] == b_pad[g*LANE_W +: LANE_W]);
  end

  assign eq_o = &lane_eq;
endmodule

// File: rtl/cas_ctrl.sv
module cas_ctrl
  import cas_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic mem_ack_i,
  input  logic match_i,
  output logic load_o,
  output logic mem_req_o,
  output logic mem_we_o,
  output logic lock_o,
  output logic done_o,
  output logic ovf_o
);
  cas_state_e st_q, st_d;
  logic       ovf_q, ovf_d;

  always_comb begin
    st_d  = st_q;
    ovf_d = ovf_q;
    unique case (st_q)
      ST_IDLE: if (start_i) st_d = ST_RD;
      ST_RD: if (mem_ack_i) begin
        if (match_i) begin
          st_d = ST_WR;
        end else begin
          st_d  = ST_FIN;
          ovf_d = 1'b0;
        end
      end
      ST_WR: if (mem_ack_i) begin
        st_d  = ST_FIN;
        ovf_d = 1'b1;
      end
      ST_FIN: st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= ST_IDLE;
      ovf_q <= 1'b0;
    end else begin
      st_q  <= st_d;
      ovf_q <= ovf_d;
    end
  end

  assign load_o    = (st_q == ST_IDLE) && start_i;
  assign mem_req_o = (st_q == ST_RD) || (st_q == ST_WR);
  assign mem_we_o  = (st_q == ST_WR);
  assign lock_o    = mem_req_o;
  assign done_o    = (st_q == ST_FIN);
  assign ovf_o     = ovf_q;

  a_r4_write_after_match: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_RD && mem_ack_i && match_i) |=> (mem_req_o && mem_we_o));

  a_r5_no_write_on_miss: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_RD && mem_ack_i && !match_i) |=> (!mem_req_o && !ovf_o && done_o));

  a_r7_done_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  a_r9_ovf_only_at_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(ovf_o) |-> done_o);
endmodule

// File: rtl/cas_unit.sv
module cas_unit #(
  parameter int AW     = 32,
  parameter int DW     = 64,
  parameter int LANE_W = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [DW-1:0] old_val_i,
  input  logic [DW-1:0] new_val_i,
  input  logic [AW-1:0] base_i,
  input  logic [AW-1:0] offset_i,
  output logic          mem_req_o,
  output logic          mem_we_o,
  output logic [AW-1:0] mem_addr_o,
  output logic [DW-1:0] mem_wdata_o,
  input  logic          mem_ack_i,
  input  logic [DW-1:0] mem_rdata_i,
  output logic          lock_o,
  output logic          ovf_o,
  output logic          done_o
);
  logic          load;
  logic          match;
  logic [DW-1:0] old_q, new_q;
  logic [AW-1:0] addr_q;

  cas_opnd_reg #(.AW(AW), .DW(DW)) u_opnd (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (load),
    .old_val_i (old_val_i),
    .new_val_i (new_val_i),
    .base_i    (base_i),
    .offset_i  (offset_i),
    .old_q_o   (old_q),
    .new_q_o   (new_q),
    .addr_q_o  (addr_q)
  );

  cas_cmp #(.DW(DW), .LANE_W(LANE_W)) u_cmp (
    .a_i  (mem_rdata_i),
    .b_i  (old_q),
    .eq_o (match)
  );

  cas_ctrl u_ctrl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (start_i),
    .mem_ack_i (mem_ack_i),
    .match_i   (match),
    .load_o    (load),
    .mem_req_o (mem_req_o),
    .mem_we_o  (mem_we_o),
    .lock_o    (lock_o),
    .done_o    (done_o),
    .ovf_o     (ovf_o)
  );

  assign mem_addr_o  = addr_q;
  assign mem_wdata_o = new_q;

  a_r6_lock_falls_after_ack: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(lock_o) |-> $past(mem_ack_i));

  a_r6_unlocked_at_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !lock_o);

  a_r10_req_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_ack_i) |=>
      (mem_req_o && $stable(mem_addr_o) && $stable(mem_we_o) && $stable(mem_wdata_o)));

  a_r3_read_first: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(mem_req_o) |-> !mem_we_o);
endmodule

// File: tb/sim_cas_unit.sv
module sim_cas_unit;
  localparam int AW = 32;
  localparam int DW = 64;
  localparam int NV = 6;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          start_i = 1'b0;
  logic [DW-1:0] old_val_i = '0, new_val_i = '0;
  logic [AW-1:0] base_i = '0, offset_i = '0;
  logic          mem_req_o, mem_we_o, lock_o, ovf_o, done_o;
  logic [AW-1:0] mem_addr_o;
  logic [DW-1:0] mem_wdata_o;
  logic          mem_ack_i = 1'b0;
  logic [DW-1:0] mem_rdata_i = '0;

  int checks = 0;
  int failures = 0;

  always #4 clk_i = ~clk_i;

  cas_unit #(.AW(AW), .DW(DW)) u0 (.*);

  // memory model: 16 words indexed by addr[3:0]
  logic [DW-1:0] mem [16];
  int lat = 0;
  int wait_cnt = 0;
  int wr_cnt = 0;

  always @(negedge clk_i) begin
    if (mem_ack_i) begin
      mem_ack_i = 1'b0;
    end else if (mem_req_o) begin
      if (wait_cnt >= lat) begin
        wait_cnt  = 0;
        mem_ack_i = 1'b1;
        if (mem_we_o) begin
          mem[mem_addr_o[3:0]] = mem_wdata_o;
          wr_cnt++;
        end else begin
          mem_rdata_i = mem[mem_addr_o[3:0]];
        end
      end else begin
        wait_cnt++;
      end
    end else begin
      wait_cnt = 0;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // stimulus table: preload, old, new, base, offset, latency, expected flag
  localparam logic [63:0] T_PRE [NV] = '{64'h1111, 64'h1111, 64'hFFFF_FFFF_FFFF_FFFF,
                                         64'h8000_0000_0000_0000, 64'h0123_4567_89AB_CDEF, 64'h0};
  localparam logic [63:0] T_OLD [NV] = '{64'h1111, 64'h1112, 64'hFFFF_FFFF_FFFF_FFFF,
                                         64'h0, 64'h0123_4567_89AB_CDEE, 64'h0};
  localparam logic [63:0] T_NEW [NV] = '{64'hAAAA, 64'h2222, 64'h0,
                                         64'h77, 64'h55, 64'h5};
  localparam logic [31:0] T_BASE[NV] = '{32'h100, 32'h208, 32'hFFFF_FFFE, 32'h30, 32'h0, 32'h0};
  localparam logic [31:0] T_OFF [NV] = '{32'h4, 32'h1, 32'h3, 32'h6, 32'h9, 32'hF};
  localparam int          T_LAT [NV] = '{0, 2, 1, 3, 0, 4};
  localparam bit          T_OVF [NV] = '{1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1};

  task automatic run_op(input logic [63:0] pre, input logic [63:0] od, input logic [63:0] nw,
                        input logic [31:0] b, input logic [31:0] o, input int l,
                        input bit exp_ovf, input bit glitch);
    logic [31:0] exp_addr;
    logic [63:0] exp_mem;
    int done_cnt, last_ack, done_cyc, bad_addr, lock_miss, lock_at_done;
    bit first_seen, first_we, late_req;
    exp_addr = b + o;
    exp_mem  = exp_ovf ? nw : pre;
    mem[exp_addr[3:0]] = pre;
    mem[7] = 64'hDEAD;
    lat = l; wr_cnt = 0;
    done_cnt = 0; last_ack = -10; done_cyc = -1; bad_addr = 0; lock_miss = 0;
    lock_at_done = 0; first_seen = 0; first_we = 0; late_req = 0;
    @(negedge clk_i);
    old_val_i = od; new_val_i = nw; base_i = b; offset_i = o; start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    for (int c = 0; c < 30; c++) begin
      if (glitch && c == 1) begin
        old_val_i = 64'hDEAD; new_val_i = 64'hBAD; base_i = 32'h7; offset_i = 32'h0;
        start_i = 1'b1;
      end
      if (c == 2) start_i = 1'b0;
      if (c > 0) @(negedge clk_i);
      #1;
      if (mem_req_o) begin
        if (!first_seen) begin first_seen = 1; first_we = mem_we_o; end
        if (mem_addr_o != exp_addr) bad_addr++;
        if (!lock_o) lock_miss++;
        if (done_cnt > 0) late_req = 1;
      end
      if (mem_ack_i) last_ack = c;
      if (done_o) begin
        done_cnt++;
        if (done_cyc < 0) done_cyc = c;
        if (lock_o) lock_at_done++;
      end
    end
    chk(first_seen && !first_we, "R3 first request is a read", 64'(first_we), 64'h0);
    chk(bad_addr == 0, "R2 request address", 64'(bad_addr), 64'h0);
    chk(lock_miss == 0, "R6 lock high during request", 64'(lock_miss), 64'h0);
    chk(lock_at_done == 0, "R6 lock low at done", 64'(lock_at_done), 64'h0);
    chk(done_cnt == 1, "R7 one done pulse", 64'(done_cnt), 64'h1);
    chk(done_cyc == last_ack + 1, "R7 done after final ack", 64'(done_cyc), 64'(last_ack + 1));
    chk(ovf_o == exp_ovf, exp_ovf ? "R4 success flag" : "R5 failure flag", 64'(ovf_o), 64'(exp_ovf));
    chk(mem[exp_addr[3:0]] == exp_mem, exp_ovf ? "R4 word replaced" : "R5 word untouched",
        mem[exp_addr[3:0]], exp_mem);
    chk(wr_cnt == (exp_ovf ? 1 : 0), exp_ovf ? "R4 one write" : "R5 no write",
        64'(wr_cnt), 64'(exp_ovf ? 1 : 0));
    if (glitch) begin
      chk(!late_req, "R8 no second operation", 64'(late_req), 64'h0);
      chk(mem[7] == 64'hDEAD, "R8 glitch operands ignored", mem[7], 64'hDEAD);
    end
  endtask

  initial begin
    #800000;
    failures++; checks++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    for (int i = 0; i < 16; i++) mem[i] = '0;
    repeat (3) @(negedge clk_i);
    #1;
    chk(!mem_req_o && !lock_o && !done_o && !ovf_o, "R1 outputs in reset",
        {60'h0, mem_req_o, lock_o, done_o, ovf_o}, 64'h0);
    rst_ni = 1'b1;
    @(negedge clk_i); #1;
    chk(!mem_req_o && !lock_o && !done_o && !ovf_o, "R1 idle after reset",
        {60'h0, mem_req_o, lock_o, done_o, ovf_o}, 64'h0);

    for (int v = 0; v < NV; v++)
      run_op(T_PRE[v], T_OLD[v], T_NEW[v], T_BASE[v], T_OFF[v], T_LAT[v], T_OVF[v], 1'b0);

    // R8: start and operand changes during a pending operation
    run_op(64'h42, 64'h42, 64'h99, 32'h10, 32'h3, 3, 1'b1, 1'b1);

    // R9: flag held between operations with inputs toggling
    base_i = 32'h5; old_val_i = 64'h1;
    repeat (5) @(negedge clk_i);
    #1;
    chk(ovf_o == 1'b1, "R9 flag held while idle", 64'(ovf_o), 64'h1);

    // R10: long wait keeps request fields stable
    begin
      logic [31:0] a0;
      logic [63:0] d0;
      int unstable;
      unstable = 0;
      lat = 6;
      mem[2] = 64'h3;
      @(negedge clk_i);
      old_val_i = 64'h9; new_val_i = 64'h4; base_i = 32'h2; offset_i = 32'h0; start_i = 1'b1;
      @(negedge clk_i); start_i = 1'b0; #1;
      a0 = mem_addr_o; d0 = mem_wdata_o;
      for (int c = 0; c < 5; c++) begin
        @(negedge clk_i); #1;
        if (!mem_req_o || mem_addr_o != a0 || mem_wdata_o != d0 || mem_we_o) unstable++;
      end
      chk(unstable == 0, "R10 request held while waiting", 64'(unstable), 64'h0);
      repeat (6) @(negedge clk_i);
    end

    // R1: reset in the middle of an operation
    lat = 20;
    @(negedge clk_i);
    old_val_i = 64'h0; base_i = 32'h1; offset_i = 32'h0; start_i = 1'b1;
    @(negedge clk_i); start_i = 1'b0;
    @(negedge clk_i);
    rst_ni = 1'b0;
    #1;
    chk(!mem_req_o && !lock_o && !done_o && !ovf_o, "R1 outputs cleared by reset",
        {60'h0, mem_req_o, lock_o, done_o, ovf_o}, 64'h0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    repeat (3) @(negedge clk_i);
    #1;
    chk(!mem_req_o && !done_o, "R1 stays idle after reset", {62'h0, mem_req_o, done_o}, 64'h0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule